// File: doc/BRIEF.md
# Snoop Result Phase Resolver

This block sits beside a shared, transaction-ordered system bus. It decides who answers a read: a caching agent or main memory. Each transaction opens a snoop window, marked by a one-cycle start strobe that carries the transaction's index. The block samples the wired-OR `hit` and `hit_mod` lines at the last edge of that window and classifies the outcome as a miss, a clean hit or a modified hit. If any agent still needs time, the window is stretched. The block then emits one tagged result.

The window is four edges long after the edge that opens it. When `hit` and `hit_mod` are both high at the sampling edge, an agent is stalling. Such a stall reopens the window for two more edges, and this may repeat any number of times. A modified hit makes the cache the responder and raises a capture enable, so memory takes a copy of the cache's data. A miss or a clean hit leaves the response with memory and does not capture.

Only one window runs at a time. Strobes that arrive while a window is open are queued. Each queued window opens at the edge where the one before it resolves, so results always come out in strobe order. The result pins are plain, one-cycle outputs with no back-pressure, because the bus cannot wait on this block. The source must not issue a strobe while the queue is full.

Top module: `snp_resolver`

## Requirements
- R1: After reset, `res_valid`, `owner_cache` and `capture_en` are low and no window is open.
- R2: With no window open, a strobe captured at edge E0 opens a window. `hit`/`hit_mod` are sampled at edge E0+4, and the result is visible in the cycle that follows that edge.
- R3: Neither line high at the sampling edge gives `res_kind` = 0 (miss). `res_kind` never takes the value 3.
- R4: Only `hit` high at the sampling edge gives `res_kind` = 1 (clean hit), with `owner_cache` = 0 and `capture_en` = 0.
- R5: Only `hit_mod` high at the sampling edge gives `res_kind` = 2 (modified hit), with `owner_cache` = 1 and `capture_en` = 1.
- R6: Both lines high at a sampling edge is a stall. No result is produced, and the next sampling edge comes two edges later. Stalls may repeat.
- R7: `res_valid` is high for exactly one cycle per transaction, and `res_idx` carries the index given with its strobe.
- R8: Results leave in strobe order. A queued window opens at the edge where the previous one resolves, so it cannot resolve before an earlier stalled window.
- R9: `hit`/`hit_mod` values at edges other than a sampling edge have no effect on any result.
- R10: Strobes accepted while a window is open are held in a queue of `QDEPTH` entries. A strobe must not be issued while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 1 | One-cycle strobe opening a transaction's snoop window |
| win_idx | input | IDX_W | Index of the transaction opening its window |
| hit | input | 1 | Wired-OR clean-hit snoop line |
| hit_mod | input | 1 | Wired-OR modified-hit snoop line |
| res_valid | output | 1 | One-cycle pulse marking a resolved result |
| res_idx | output | IDX_W | Transaction index of the result |
| res_kind | output | 2 | 0 miss, 1 clean hit, 2 modified hit |
| owner_cache | output | 1 | Cache supplies the response (otherwise memory does) |
| capture_en | output | 1 | Memory must capture the data the cache transfers |

## Verification
The bench drives deliberately conflicting values on `hit`/`hit_mod` on the edges before the sampling edge. A resolver that samples one edge early or late then reports the wrong kind. The single-stall and triple-stall cases catch a stretch of the wrong length, which would resolve two edges off or take the stall code as a modified hit. The ordered pair starts a second window one cycle after the first and stalls the first. It also shows the second window a modified-hit code at its own nominal sampling edge. A design that overlapped windows, or opened the queued one at its strobe time, would then report it early or report it out of order.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    SNP_MISS  = 2'd0,
    SNP_CLEAN = 2'd1,
    SNP_MOD   = 2'd2
  } snp_kind_e;

  // Classify the two snoop lines at a sampling edge (stall excluded by caller)
  function automatic snp_kind_e snp_classify(input logic h, input logic hm);
    if (hm)     return SNP_MOD;
    else if (h) return SNP_CLEAN;
    else        return SNP_MISS;
  endfunction

endpackage

// File: rtl/snp_order_fifo.sv
module snp_order_fifo #(
  parameter int DEPTH = 2,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rd_p];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) begin
        mem[wr_p] <= din;
        wr_p      <= nxt(wr_p);
      end
      if (pop) rd_p <= nxt(rd_p);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/snp_window_timer.sv
module snp_window_timer #(
  parameter int WIN_LEN   = 4,
  parameter int STALL_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hit,
  input  logic hit_mod,
  output logic busy,
  output logic sample_now,
  output logic done
);
  localparam int MAXL = (WIN_LEN > STALL_LEN) ? WIN_LEN : STALL_LEN;
  localparam int CW   = (MAXL > 1) ? $clog2(MAXL) : 1;

  logic [CW-1:0] cnt;
  logic          stall;

  assign sample_now = busy && (cnt == '0);
  assign stall      = hit && hit_mod;
  assign done       = sample_now && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= CW'(WIN_LEN - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        if (stall) cnt  <= CW'(STALL_LEN - 1);
        else       busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/snp_resolver.sv
module snp_resolver
  import snp_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int QDEPTH    = 2,
  parameter int WIN_LEN   = 4,
  parameter int STALL_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_start,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             hit,
  input  logic             hit_mod,
  output logic             res_valid,
  output logic [IDX_W-1:0] res_idx,
  output logic [1:0]       res_kind,
  output logic             owner_cache,
  output logic             capture_en
);
  logic             busy, sample_now, done;
  logic             take, use_q, use_in, load, push;
  logic             q_empty, q_full;
  logic [IDX_W-1:0] q_head, act_idx;
  snp_kind_e        kind;

  assign take   = !busy || done;
  assign use_q  = take && !q_empty;
  assign use_in = take && q_empty && win_start;
  assign load   = use_q || use_in;
  assign push   = win_start && !use_in;
  assign kind   = snp_classify(hit, hit_mod);

  snp_order_fifo #(.DEPTH(QDEPTH), .DW(IDX_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .din(win_idx), .pop(use_q),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  snp_window_timer #(.WIN_LEN(WIN_LEN), .STALL_LEN(STALL_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .hit(hit), .hit_mod(hit_mod),
    .busy(busy), .sample_now(sample_now), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_idx <= '0;
    end else if (load) begin
      act_idx <= use_q ? q_head : win_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_idx     <= '0;
      res_kind    <= SNP_MISS;
      owner_cache <= 1'b0;
      capture_en  <= 1'b0;
    end else begin
      res_valid   <= done;
      res_idx     <= done ? act_idx : '0;
      res_kind    <= done ? kind : SNP_MISS;
      owner_cache <= done && (kind == SNP_MOD);
      capture_en  <= done && (kind == SNP_MOD);
    end
  end
endmodule

// File: rtl/snp_resolver_chk.sv
module snp_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       win_start,
  input logic       q_full,
  input logic       sample_now,
  input logic       hit,
  input logic       hit_mod,
  input logic       res_valid,
  input logic [1:0] res_kind,
  input logic       owner_cache,
  input logic       capture_en
);
  // R10: source never strobes into a full queue
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |-> !q_full);

  // R5: modified hit hands response to cache and captures
  p_mod_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd2) |-> (owner_cache && capture_en));

  // R4: other outcomes stay with memory
  p_mem_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != 2'd2) |-> (!owner_cache && !capture_en));

  // R3: reserved kind code never appears
  p_kind_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_kind != 2'd3));

  // R7: result is a single-cycle pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R6: a stall at a sampling edge yields no result
  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_now && hit && hit_mod) |=> !res_valid);

  // R1: no result and no ownership outside a valid pulse
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!owner_cache && !capture_en));
endmodule

bind snp_resolver snp_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .win_start(win_start), .q_full(q_full),
  .sample_now(sample_now), .hit(hit), .hit_mod(hit_mod),
  .res_valid(res_valid), .res_kind(res_kind),
  .owner_cache(owner_cache), .capture_en(capture_en)
);

// File: tb/test_snp_resolver.sv
module test_snp_resolver;
  localparam int CLK_P = 10;
  localparam int IW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          win_start = 1'b0;
  logic [IW-1:0] win_idx = '0;
  logic          hit = 1'b0, hit_mod = 1'b0;
  logic          res_valid, owner_cache, capture_en;
  logic [IW-1:0] res_idx;
  logic [1:0]    res_kind;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  snp_resolver i_snp_resolver (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_idx(win_idx),
    .hit(hit), .hit_mod(hit_mod), .res_valid(res_valid), .res_idx(res_idx),
    .res_kind(res_kind), .owner_cache(owner_cache), .capture_en(capture_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Single window: nst stalls, final lines fh/fm, noisy lines elsewhere (R9)
  task automatic run_one(input logic [IW-1:0] idx, input int nst,
                         input logic fh, input logic fm, input string req);
    int last;
    last = 4 + 2*nst;
    @(negedge clk);
    win_start = 1'b1; win_idx = idx; hit = 1'b1; hit_mod = 1'b0;
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      chk({req, " R2 no early result"}, int'(res_valid), 0);
      win_start = 1'b0;
      if (c == last) begin
        hit = fh; hit_mod = fm;
      end else if (c >= 4 && ((c - 4) % 2 == 0)) begin
        hit = 1'b1; hit_mod = 1'b1;          // R6 stall at sampling edge
      end else begin
        hit = c[0]; hit_mod = ~c[0];         // R9 off-edge noise
      end
    end
    @(negedge clk);
    hit = 1'b0; hit_mod = 1'b0;
    chk({req, " R7 valid"}, int'(res_valid), 1);
    chk({req, " R7 idx"}, int'(res_idx), int'(idx));
    chk({req, " kind"}, int'(res_kind), fm ? 2 : (fh ? 1 : 0));
    chk({req, " R5 owner"}, int'(owner_cache), int'(fm));
    chk({req, " R5 capture"}, int'(capture_en), int'(fm));
    @(negedge clk);
    chk({req, " R7 one pulse"}, int'(res_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 owner", int'(owner_cache), 0);
    chk("R1 capture", int'(capture_en), 0);
  endtask

  task automatic t_miss();      run_one(4'd3, 0, 1'b0, 1'b0, "R3 miss");     endtask
  task automatic t_clean();     run_one(4'd5, 0, 1'b1, 1'b0, "R4 clean");    endtask
  task automatic t_mod();       run_one(4'd9, 0, 1'b0, 1'b1, "R5 mod");      endtask
  task automatic t_one_stall(); run_one(4'd6, 1, 1'b1, 1'b0, "R6 stall1");   endtask
  task automatic t_three();     run_one(4'd12, 3, 1'b0, 1'b1, "R6 stall3");  endtask

  // R8/R10: A at N0, B at N1 (queued); A stalls once, B opens at A's resolve
  task automatic t_order();
    @(negedge clk);
    win_start = 1'b1; win_idx = 4'd7;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      chk("R8 valid timing", int'(res_valid), (c == 7 || c == 11) ? 1 : 0);
      if (c == 7) begin
        chk("R8 first idx", int'(res_idx), 7);
        chk("R8 first kind", int'(res_kind), 1);
      end
      if (c == 11) begin
        chk("R8 second idx", int'(res_idx), 2);
        chk("R8 second kind", int'(res_kind), 2);
        chk("R8 second capture", int'(capture_en), 1);
      end
      win_start = (c == 1); win_idx = 4'd2;
      hit     = (c == 4) || (c == 6);
      hit_mod = (c == 4) || (c == 5) || (c == 10);
    end
    hit = 1'b0; hit_mod = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss();
    t_clean();
    t_mod();
    t_one_stall();
    t_three();
    t_order();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule